// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction Unit

This block turns one 4x4 tile of signed 16-bit dequantized transform coefficients into a tile of reconstructed 8-bit pixels. It applies a separable integer inverse transform. The first 1-D butterfly pass runs over the columns of the coefficient tile, and a second pass runs over the rows of the intermediate result. The butterfly uses two fixed-point rotation constants and saturates every sum and difference to 16 bits. Each value from the second pass is rounded and scaled down by eight. It is then added to the matching prediction pixel at wider precision and clamped to the 8-bit pixel range.

A caller presents both tiles on wide parallel inputs and pulses `start`. The unit copies the tiles into internal registers, so the inputs may change from the next cycle onward. A single shared butterfly handles one column or one row per cycle. After a fixed eight-step sequence, `done` pulses for one cycle and the reconstructed tile appears on `pix_out`. Dequantization, prediction and memory addressing are handled elsewhere.

Top module: `idct4_recon`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low and after it is released, `done` is 0 and every pixel of `pix_out` is 0. An operation in progress when reset arrives is abandoned and never signals `done`.
- R2: A rising clock edge that samples `start` high while no operation is in progress captures `coef_in` and `pred_in`. `done` is 0 after edges 1 to 7 that follow this capturing edge. It is 1 after edge 8, and at that point `pix_out` holds the result for the captured tiles, whatever the inputs did after capture.
- R3: `done` stays high for exactly one clock cycle per operation.
- R4: `start` sampled while an operation is in progress is ignored. The running operation keeps its timing and its result.
- R5: The two constant multiplies on a 16-bit value x are M1(x) = x + floor(x*20091 / 65536) and M2(x) = floor(x*35468 / 65536). Floor rounds toward minus infinity.
- R6: Coefficient k, with k = 4*row + column, sits at `coef_in[16k+15:16k]`. Prediction and output pixel k sit at bits `[8k+7:8k]` of `pred_in` and `pix_out`. A 1-D pass on inputs (e0, e1, e2, e3) forms a = e0+e2, b = e0-e2, c = M2(e1)-M1(e3) and d = M1(e1)+M2(e3), and outputs a+d, b+c, b-c, a-d in that order. Pass one on column j reads coefficients j, j+4, j+8, j+12 and writes intermediates 4j..4j+3. Pass two on row i reads intermediates i, i+4, i+8, i+12, and its four outputs become pixels 4i..4i+3.
- R7: Every sum and difference in both passes saturates to the signed 16-bit range -32768..32767. The sum inside M1 saturates in the same way.
- R8: Each second-pass value v becomes the residual (v+4) shifted right arithmetically by 3. This is computed in 17 bits, so v = 32767 gives 4096 without wrapping.
- R9: The residual is added to the zero-extended prediction pixel at wider precision. The sum is then clamped to 0..255 to form the output pixel.
- R10: When no operation is in progress, `pix_out` holds its last value regardless of `coef_in` and `pred_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation on the presented tiles when idle |
| coef_in | input | 256 | Sixteen signed 16-bit coefficients, raster order |
| pred_in | input | 128 | Sixteen unsigned 8-bit prediction pixels, raster order |
| pix_out | output | 128 | Sixteen reconstructed 8-bit pixels, raster order |
| done | output | 1 | One-cycle pulse marking `pix_out` valid |

## Verification
The checker assumes that `start` is the only request, and it counts cycles from the first `start` accepted while the unit is idle. It expects `done` after exactly eight further edges. It expects `pix_out` to change only while an operation is running, and it needs no assumption about coefficient or prediction values. The stimulus keeps to this contract. It raises `start` for a single cycle at each request and drives one extra pulse deliberately in the middle of a run. It applies reset only at a clock boundary, including once partway through an operation. The tile vectors cover the full signed coefficient range, including both saturation extremes, so no input value lies outside what the design accepts.

// File: rtl/idct4_pkg.sv
// Package idct4_pkg
// Shared constants for the 4x4 inverse transform and reconstruction unit.
// Assumes a square 4x4 tile; the butterfly is defined only for four points.
package idct4_pkg;
    localparam int TILE_DIM   = 4;
    localparam int TILE_N     = TILE_DIM * TILE_DIM;
    localparam int COEF_W     = 16;
    localparam int PIX_W      = 8;
    localparam int ROT_K1     = 20091;
    localparam int ROT_K2     = 35468;
    localparam int MUL_SHIFT  = 16;
    localparam int RND_SHIFT  = 3;
    localparam int PASS_STEPS = 2 * TILE_DIM;
endpackage

// File: rtl/idct4_seq.sv
// Module idct4_seq
// Step sequencer. It accepts a start request only while idle, walks
// STEPS steps (column phase first, then row phase) and pulses done once.
// Assumes STEPS is a power of two, so the top step bit selects the phase.
module idct4_seq #(
    parameter int STEPS = idct4_pkg::PASS_STEPS,
    localparam int SBW  = $clog2(STEPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           load,
    output logic           busy,
    output logic           row_ph,
    output logic [SBW-2:0] idx,
    output logic           done
);
    logic [SBW-1:0] step_q;
    logic           busy_q;
    logic           done_q;

    // accept a new request only when no operation is running
    assign load = start && !busy_q;

    // advance the step counter and raise done after the last step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                busy_q <= 1'b1;
                step_q <= '0;
            end else if (busy_q) begin
                if (step_q == SBW'(STEPS - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign row_ph = step_q[SBW-1];
    assign idx    = step_q[SBW-2:0];
endmodule

// File: rtl/idct4_pass.sv
// Module idct4_pass
// Combinational four-point inverse butterfly with fixed-point rotations.
// Every sum and difference saturates to CW bits. x[1] and x[3] are the
// odd inputs that feed the rotation constants.
module idct4_pass #(
    parameter int CW  = idct4_pkg::COEF_W,
    parameter int K1  = idct4_pkg::ROT_K1,
    parameter int K2  = idct4_pkg::ROT_K2,
    parameter int MSH = idct4_pkg::MUL_SHIFT
) (
    input  logic signed [CW-1:0] x [4],
    output logic signed [CW-1:0] y [4]
);
    localparam int SW = CW + 2;
    localparam int PW = 2 * CW + 2;
    localparam logic signed [SW-1:0] SAT_HI = {{(SW-CW+1){1'b0}}, {(CW-1){1'b1}}};
    localparam logic signed [SW-1:0] SAT_LO = {{(SW-CW+1){1'b1}}, {(CW-1){1'b0}}};

    // clamp a widened value into the signed CW-bit range
    function automatic logic signed [CW-1:0] sat(input logic signed [SW-1:0] v);
        if (v > SAT_HI)      return SAT_HI[CW-1:0];
        else if (v < SAT_LO) return SAT_LO[CW-1:0];
        else                 return v[CW-1:0];
    endfunction

    // multiply by an unsigned constant and keep the high part, flooring
    function automatic logic signed [SW-1:0] mulk(input logic signed [CW-1:0] v,
                                                  input int k);
        logic signed [PW-1:0] p;
        p = PW'(v) * $signed(PW'(k));
        return SW'(p >>> MSH);
    endfunction

    logic signed [CW-1:0] m1_odd, m2_odd, m1_far, m2_far;
    logic signed [CW-1:0] a, b, c, d;

    // rotation products of the two odd inputs
    always_comb begin
        m1_odd = sat(SW'(x[1]) + mulk(x[1], K1));
        m2_odd = sat(mulk(x[1], K2));
        m1_far = sat(SW'(x[3]) + mulk(x[3], K1));
        m2_far = sat(mulk(x[3], K2));
    end

    // even and odd partial terms
    always_comb begin
        a = sat(SW'(x[0]) + SW'(x[2]));
        b = sat(SW'(x[0]) - SW'(x[2]));
        c = sat(SW'(m2_odd) - SW'(m1_far));
        d = sat(SW'(m1_odd) + SW'(m2_far));
    end

    // output combination in fixed order
    always_comb begin
        y[0] = sat(SW'(a) + SW'(d));
        y[1] = sat(SW'(b) + SW'(c));
        y[2] = sat(SW'(b) - SW'(c));
        y[3] = sat(SW'(a) - SW'(d));
    end
endmodule

// File: rtl/idct4_recon_px.sv
// Module idct4_recon_px
// One reconstruction lane: rounds a second-pass value by 2^RSH, adds the
// zero-extended prediction pixel and clamps to the unsigned pixel range.
// Assumes CW > PW so that the widened sum never wraps.
module idct4_recon_px #(
    parameter int CW  = idct4_pkg::COEF_W,
    parameter int PW  = idct4_pkg::PIX_W,
    parameter int RSH = idct4_pkg::RND_SHIFT
) (
    input  logic signed [CW-1:0] resid_raw,
    input  logic        [PW-1:0] pred,
    output logic        [PW-1:0] pix
);
    localparam int RW = CW + 1;
    localparam int AW = RW + 1;
    localparam logic signed [AW-1:0] PIX_MAX = AW'((1 << PW) - 1);

    logic signed [RW-1:0] rnd;
    logic signed [AW-1:0] sum;

    // round to nearest with the offset added before the shift
    always_comb rnd = (RW'(resid_raw) + RW'(1 << (RSH - 1))) >>> RSH;

    // add the prediction at full precision
    always_comb sum = AW'(rnd) + $signed(AW'(pred));

    // clamp to the pixel range
    always_comb begin
        if (sum < 0)            pix = '0;
        else if (sum > PIX_MAX) pix = PIX_MAX[PW-1:0];
        else                    pix = sum[PW-1:0];
    end
endmodule

// File: rtl/idct4_recon.sv
// Module idct4_recon (top)
// Captures a coefficient tile and a prediction tile on start, runs a column
// pass then a row pass through one shared butterfly (one line per cycle),
// reconstructs each row as it leaves the second pass and pulses done.
// Assumes a 4x4 tile in raster order; pix_out changes only during row steps.
module idct4_recon
    import idct4_pkg::*;
#(
    parameter int CW  = COEF_W,
    parameter int PW  = PIX_W,
    parameter int K1  = ROT_K1,
    parameter int K2  = ROT_K2,
    parameter int MSH = MUL_SHIFT,
    parameter int RSH = RND_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [TILE_N*CW-1:0]   coef_in,
    input  logic [TILE_N*PW-1:0]   pred_in,
    output logic [TILE_N*PW-1:0]   pix_out,
    output logic                   done
);
    localparam int D   = TILE_DIM;
    localparam int N   = TILE_N;
    localparam int IW  = $clog2(D);

    logic signed [CW-1:0] coef_q [N];
    logic        [PW-1:0] pred_q [N];
    logic signed [CW-1:0] mid_q  [N];
    logic        [PW-1:0] pix_q  [N];

    logic          load, busy, row_ph;
    logic [IW-1:0] idx;

    logic signed [CW-1:0] bf_in  [4];
    logic signed [CW-1:0] bf_out [4];
    logic        [PW-1:0] pred_sel [D];
    logic        [PW-1:0] lane_pix [D];

    idct4_seq #(.STEPS(PASS_STEPS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .busy   (busy),
        .row_ph (row_ph),
        .idx    (idx),
        .done   (done)
    );

    // capture both input tiles when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                coef_q[k] <= '0;
                pred_q[k] <= '0;
            end
        end else if (load) begin
            for (int k = 0; k < N; k++) begin
                coef_q[k] <= coef_in[k*CW +: CW];
                pred_q[k] <= pred_in[k*PW +: PW];
            end
        end
    end

    // pick a coefficient column or an intermediate row, strided by the tile width
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            bf_in[k] = row_ph ? mid_q[k*D + int'(idx)] : coef_q[k*D + int'(idx)];
        end
    end

    idct4_pass #(.CW(CW), .K1(K1), .K2(K2), .MSH(MSH)) u_pass (
        .x (bf_in),
        .y (bf_out)
    );

    // store the column-pass outputs contiguously, which transposes the tile
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) mid_q[k] <= '0;
        end else if (busy && !row_ph) begin
            for (int k = 0; k < D; k++) mid_q[int'(idx)*D + k] <= bf_out[k];
        end
    end

    // prediction pixels of the row being reconstructed
    always_comb begin
        for (int k = 0; k < D; k++) pred_sel[k] = pred_q[int'(idx)*D + k];
    end

    for (genvar g = 0; g < D; g++) begin : g_lane
        idct4_recon_px #(.CW(CW), .PW(PW), .RSH(RSH)) u_px (
            .resid_raw (bf_out[g]),
            .pred      (pred_sel[g]),
            .pix       (lane_pix[g])
        );
    end

    // write one reconstructed row per row-phase step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) pix_q[k] <= '0;
        end else if (busy && row_ph) begin
            for (int k = 0; k < D; k++) pix_q[int'(idx)*D + k] <= lane_pix[k];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_pack
        assign pix_out[g*PW +: PW] = pix_q[g];
    end
endmodule

// File: rtl/idct4_recon_chk.sv
// Module idct4_recon_chk
// Protocol checker bound to idct4_recon. It tracks the latency from an
// accepted start with its own counter, and checks the done pulse shape and
// that the output tile holds while the unit is idle.
module idct4_recon_chk #(
    parameter int LAT = idct4_pkg::PASS_STEPS,
    parameter int OW  = idct4_pkg::TILE_N * idct4_pkg::PIX_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [OW-1:0] pix_out
);
    localparam int CBW = $clog2(LAT + 1) + 1;

    logic           tracking;
    logic [CBW-1:0] since;

    // count edges since the most recently accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tracking <= 1'b0;
            since    <= '0;
        end else begin
            if (done) tracking <= 1'b0;
            if (start && !busy) begin
                tracking <= 1'b1;
                since    <= '0;
            end else if (tracking) begin
                since <= since + 1'b1;
            end
        end
    end

    // done arrives exactly LAT edges after acceptance; a start while busy
    // does not restart the count (R4)
    p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tracking && since == CBW'(LAT)));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(pix_out));
endmodule

bind idct4_recon idct4_recon_chk #(
    .LAT (idct4_pkg::PASS_STEPS),
    .OW  (idct4_pkg::TILE_N * PW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .pix_out (pix_out)
);

// File: tb/idct4_recon_tb.sv
`timescale 1ns/1ps
module idct4_recon_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] coef_in = '0;
    logic [127:0] pred_in = '0;
    logic [127:0] pix_out;
    logic         done;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    idct4_recon u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .coef_in(coef_in), .pred_in(pred_in),
        .pix_out(pix_out), .done(done)
    );

    localparam int NV = 8;
    localparam logic [255:0] T_COEF [NV] = '{
        {240'd0, 16'd80},
        256'd0,
        {16{16'h7FFF}},
        {16{16'h8000}},
        {176'd0, 16'd1000, 64'd0},
        {224'd0, 16'hF830, 16'd0},
        {16'h0100, 16'hFF00, 16'h0050, 16'hFFB0, 16'h0400, 16'hFC00, 16'h0020, 16'h7000,
         16'h8000, 16'h0010, 16'hFFF0, 16'h0200, 16'h0123, 16'hFEDC, 16'h0333, 16'h0555},
        {16'd12345, 240'd0}
    };
    localparam logic [127:0] T_PRED [NV] = '{
        {16{8'd100}},
        128'h00112233445566778899AABBCCDDEEFF,
        {16{8'd128}},
        {16{8'd128}},
        {16{8'd64}},
        {16{8'd200}},
        128'hF0E0D0C0B0A090807060504030201000,
        {16{8'd10}}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R9";
            2, 3:    return "R7";
            4, 7:    return "R5";
            default: return "R6";
        endcase
    endfunction

    // reference model written from the requirements
    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int mul1(input int x);
        return sat16(x + ((x * 20091) >>> 16));
    endfunction

    function automatic int mul2(input int x);
        return sat16((x * 35468) >>> 16);
    endfunction

    function automatic void bfly(input int e0, input int e1, input int e2, input int e3,
                                 output int o0, output int o1, output int o2, output int o3);
        int a, b, c, d;
        a = sat16(e0 + e2);
        b = sat16(e0 - e2);
        c = sat16(mul2(e1) - mul1(e3));
        d = sat16(mul1(e1) + mul2(e3));
        o0 = sat16(a + d);
        o1 = sat16(b + c);
        o2 = sat16(b - c);
        o3 = sat16(a - d);
    endfunction

    function automatic logic [127:0] model(input logic [255:0] c, input logic [127:0] p);
        int cf[16];
        int mid[16];
        int o[4];
        logic [127:0] r;
        for (int k = 0; k < 16; k++) cf[k] = int'($signed(c[16*k +: 16]));
        for (int j = 0; j < 4; j++)
            bfly(cf[j], cf[j+4], cf[j+8], cf[j+12],
                 mid[4*j], mid[4*j+1], mid[4*j+2], mid[4*j+3]);
        for (int i = 0; i < 4; i++) begin
            bfly(mid[i], mid[i+4], mid[i+8], mid[i+12], o[0], o[1], o[2], o[3]);
            for (int k = 0; k < 4; k++) begin
                int s;
                s = ((o[k] + 4) >>> 3) + int'(p[8*(4*i+k) +: 8]);
                if (s < 0) s = 0;
                if (s > 255) s = 255;
                r[8*(4*i+k) +: 8] = 8'(s);
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one operation; intrude adds a start pulse while busy (R4)
    task automatic run_op(input logic [255:0] c, input logic [127:0] p,
                          input bit intrude, output logic [127:0] got);
        @(negedge clk);
        coef_in = c;
        pred_in = p;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start   = 1'b0;
        coef_in = ~c;
        pred_in = ~p;
        for (int e = 1; e <= 7; e++) begin
            start = intrude && (e == 3);
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b0, "R2 early done", 128'(done), 128'd0);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1, "R2 done after edge 8", 128'(done), 128'd1);
        got = pix_out;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R3 done width", 128'(done), 128'd0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [127:0] got, exp, prev;
        bit seen;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && pix_out == '0, "R1 in reset", pix_out, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && pix_out == '0, "R1 after release", pix_out, 128'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            run_op(T_COEF[i], T_PRED[i], 1'b0, got);
            exp = model(T_COEF[i], T_PRED[i]);
            check(got == exp, vec_tag(i), got, exp);
        end

        // DC-only tile: (80+4)>>3 = 10, plus 100 on every pixel (R8, R9)
        run_op(T_COEF[0], T_PRED[0], 1'b0, got);
        check(got == {16{8'd110}}, "R8 DC known answer", got, {16{8'd110}});

        // start while busy is ignored (R4)
        run_op(T_COEF[6], T_PRED[6], 1'b1, got);
        exp = model(T_COEF[6], T_PRED[6]);
        check(got == exp, "R4 intrusion result", got, exp);

        // outputs hold while idle with changing inputs (R10)
        prev = pix_out;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            coef_in = {8{32'(k * 7919)}};
            pred_in = {4{32'(k * 104729)}};
        end
        @(negedge clk);
        check(pix_out == prev && done == 1'b0, "R10 idle hold", pix_out, prev);

        // reset in the middle of an operation (R1)
        @(negedge clk);
        coef_in = T_COEF[2];
        pred_in = T_PRED[2];
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(!seen, "R1 abandoned op", 128'(seen), 128'd0);
        check(pix_out == '0, "R1 cleared output", pix_out, 128'd0);

        // back-to-back operation after reset still works (R2)
        run_op(T_COEF[3], T_PRED[1], 1'b0, got);
        exp = model(T_COEF[3], T_PRED[1]);
        check(got == exp, "R7 after reset", got, exp);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule